// File: doc/BRIEF.md
# Phase-Histogram IQ Imbalance Estimator

This block watches a stream of phase codes from a phase-domain quantizer. A valid strobe marks each real sample. It never sees amplitude. It sorts every accepted phase into regions of the IQ plane and keeps three signed tallies:
- left against right, for the in-phase offset;
- lower against upper, for the quadrature offset;
- phases lying near the I axis against phases lying near the Q axis, for the gain mismatch.

At the end of each observation window the tallies are compared with a dead band. Each of three saturating compensation words then moves by at most one step, in the direction that reduces its imbalance. All tallies are then cleared.

The three words feed an analog correction stage outside the block, which closes the loop. The estimator keeps stepping until the sample distribution is balanced. A settled flag rises after a run of windows in which no word moved.

Top module: `iq_phase_balance_est`

## Requirements
- R1: The two MSBs of `ph_code` give the quadrant: 00 covers 0–90°, 01 covers 90–180°, 10 covers 180–270° and 11 covers 270–360°. Quadrants 00 and 11 count +1 and quadrants 01 and 10 count −1 in the in-phase tally. `comp_i` steps against the sign of that tally.
- R2: Quadrants 00 and 01 count +1 and quadrants 10 and 11 count −1 in the quadrature tally. `comp_q` steps against its sign.
- R3: The code is rotated by adding 2^(PH_W−3) modulo 2^PH_W. The quadrant of the rotated code is then taken. Rotated quadrants 00 and 10 (within ±45° of the I axis) count +1 in the gain tally, and rotated quadrants 01 and 11 count −1. `comp_g` steps against its sign.
- R4: At window end, a tally greater than `dead_band` lowers its word by one, and a tally less than −`dead_band` raises it by one. A tally whose magnitude equals or is below `dead_band` leaves the word unchanged.
- R5: All words reset to 0. They change only on the clock edge that accepts the last sample of a window, and are visible in the following cycle.
- R6: Words saturate at +2^(CW−1)−1 and −2^(CW−1) and never wrap.
- R7: `settled` rises once SETTLE_WINS consecutive windows have closed with no word changing. It clears on the edge at which any word changes, and is 0 after reset.
- R8: Samples presented with `ph_valid` low neither count toward the tallies nor advance the window.
- R9: A window holds 2^`win_log` valid samples. Values above WIN_LOG_MAX are treated as WIN_LOG_MAX. A window of 2^WIN_LOG_MAX identical samples produces a correctly signed tally with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ph_valid | input | 1 | Sample strobe for `ph_code` |
| ph_code | input | PH_W | Unsigned phase code, full scale = 360° |
| win_log | input | $clog2(WIN_LOG_MAX+1) | Base-2 log of the window length |
| dead_band | input | WIN_LOG_MAX+1 | Unsigned tally threshold |
| comp_i | output | CW | Signed in-phase offset correction |
| comp_q | output | CW | Signed quadrature offset correction |
| comp_g | output | CW | Signed gain-mismatch correction |
| settled | output | 1 | High after SETTLE_WINS quiet windows |

## Verification
The sample that closes a window must still contribute to the tally that is judged on that same edge, while the accumulators are being cleared. A window of one sample (`win_log` = 0) makes every sample do both things at once. Long runs of such windows are driven, and the bench expects exactly one LSB per sample until each word pins at its rail. Losing either the last contribution or the clear would leave the wrong step count or the wrong direction.

// File: rtl/iqb_pkg.sv
`timescale 1ns/1ps
package iqb_pkg;
  typedef enum logic [1:0] {STEP_HOLD = 2'd0, STEP_UP = 2'd1, STEP_DOWN = 2'd2} step_e;

  localparam int AXES = 3;
  localparam int AX_I = 0;
  localparam int AX_Q = 1;
  localparam int AX_G = 2;

  // quadrant 00 or 11 lies right of the Q axis
  function automatic logic in_right(input logic [1:0] quad);
    return (quad == 2'b00) || (quad == 2'b11);
  endfunction

  // quadrant 00 or 01 lies above the I axis
  function automatic logic in_top(input logic [1:0] quad);
    return quad[1] == 1'b0;
  endfunction

  // quadrant of the 45-degree-rotated code: even -> near I axis
  function automatic logic near_i_axis(input logic [1:0] rot_quad);
    return rot_quad[0] == 1'b0;
  endfunction

  function automatic step_e step_of(input int tally, input int band);
    if (tally > band)  return STEP_DOWN;
    if (tally < -band) return STEP_UP;
    return STEP_HOLD;
  endfunction

  function automatic int sat_apply(input int cur, input step_e st, input int lo, input int hi);
    case (st)
      STEP_UP:   return (cur >= hi) ? hi : cur + 1;
      STEP_DOWN: return (cur <= lo) ? lo : cur - 1;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/iqb_sector_decode.sv
`timescale 1ns/1ps
module iqb_sector_decode
  import iqb_pkg::*;
#(
  parameter int PH_W = 8
) (
  input  logic [PH_W-1:0] ph_code,
  output logic [AXES-1:0] vote
);
  localparam logic [PH_W-1:0] ROT = PH_W'(1) << (PH_W - 3);

  logic [PH_W-1:0] rot_code;

  always_comb begin
    rot_code   = ph_code + ROT;
    vote[AX_I] = in_right(ph_code[PH_W-1 -: 2]);
    vote[AX_Q] = in_top(ph_code[PH_W-1 -: 2]);
    vote[AX_G] = near_i_axis(rot_code[PH_W-1 -: 2]);
  end
endmodule

// File: rtl/iqb_vote_acc.sv
`timescale 1ns/1ps
module iqb_vote_acc #(
  parameter int ACC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp,
  input  logic                    close,
  input  logic                    vote,
  output logic signed [ACC_W-1:0] tally_fin
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] inc;

  assign inc       = vote ? ACC_W'(1) : '1;
  assign tally_fin = acc + inc;

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (smp) acc <= close ? '0 : tally_fin;
  end
endmodule

// File: rtl/iqb_window_ctl.sv
`timescale 1ns/1ps
module iqb_window_ctl #(
  parameter int WIN_LOG_MAX = 10,
  parameter int LW          = 4,
  parameter int CNT_W       = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic [LW-1:0] win_log,
  output logic          win_end
);
  logic [LW-1:0]    log_eff;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] cnt;

  assign log_eff  = (win_log > LW'(WIN_LOG_MAX)) ? LW'(WIN_LOG_MAX) : win_log;
  assign last_idx = (CNT_W'(1) << log_eff) - CNT_W'(1);
  assign win_end  = smp && (cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (smp) cnt <= win_end ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/iqb_comp_step.sv
`timescale 1ns/1ps
module iqb_comp_step
  import iqb_pkg::*;
#(
  parameter int CW    = 8,
  parameter int ACC_W = 12,
  parameter int DB_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    close,
  input  logic signed [ACC_W-1:0] tally_fin,
  input  logic [DB_W-1:0]         dead_band,
  output logic signed [CW-1:0]    comp,
  output logic                    moved
);
  localparam int HI = (1 << (CW - 1)) - 1;
  localparam int LO = -(1 << (CW - 1));

  step_e st;
  int    nxt;

  always_comb begin
    st    = step_of(int'(tally_fin), int'({1'b0, dead_band}));
    nxt   = sat_apply(int'(comp), st, LO, HI);
    moved = close && (nxt != int'(comp));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     comp <= '0;
    else if (moved) comp <= CW'(nxt);
  end
endmodule

// File: rtl/iq_phase_balance_est.sv
`timescale 1ns/1ps
module iq_phase_balance_est
  import iqb_pkg::*;
#(
  parameter int PH_W        = 8,
  parameter int WIN_LOG_MAX = 10,
  parameter int CW          = 8,
  parameter int SETTLE_WINS = 3,
  localparam int LW         = $clog2(WIN_LOG_MAX + 1),
  localparam int DB_W       = WIN_LOG_MAX + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ph_valid,
  input  logic [PH_W-1:0]      ph_code,
  input  logic [LW-1:0]        win_log,
  input  logic [DB_W-1:0]      dead_band,
  output logic signed [CW-1:0] comp_i,
  output logic signed [CW-1:0] comp_q,
  output logic signed [CW-1:0] comp_g,
  output logic                 settled
);
  localparam int CNT_W = WIN_LOG_MAX + 1;
  localparam int ACC_W = WIN_LOG_MAX + 2;
  localparam int QW    = $clog2(SETTLE_WINS + 1);

  logic [AXES-1:0]         vote;
  logic                    win_end;
  logic [AXES-1:0]         moved;
  logic                    any_change;
  logic signed [ACC_W-1:0] tally_fin [AXES];
  logic signed [CW-1:0]    comp_w    [AXES];
  logic [QW-1:0]           quiet;

  iqb_sector_decode #(.PH_W(PH_W)) u_dec (
    .ph_code (ph_code),
    .vote    (vote)
  );

  iqb_window_ctl #(.WIN_LOG_MAX(WIN_LOG_MAX), .LW(LW), .CNT_W(CNT_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp     (ph_valid),
    .win_log (win_log),
    .win_end (win_end)
  );

  for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
    iqb_vote_acc #(.ACC_W(ACC_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp       (ph_valid),
      .close     (win_end),
      .vote      (vote[ax]),
      .tally_fin (tally_fin[ax])
    );
    iqb_comp_step #(.CW(CW), .ACC_W(ACC_W), .DB_W(DB_W)) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .close     (win_end),
      .tally_fin (tally_fin[ax]),
      .dead_band (dead_band),
      .comp      (comp_w[ax]),
      .moved     (moved[ax])
    );
  end

  assign comp_i     = comp_w[AX_I];
  assign comp_q     = comp_w[AX_Q];
  assign comp_g     = comp_w[AX_G];
  assign any_change = win_end && (|moved);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet   <= '0;
      settled <= 1'b0;
    end else if (win_end) begin
      if (any_change) begin
        quiet   <= '0;
        settled <= 1'b0;
      end else begin
        if (quiet != QW'(SETTLE_WINS)) quiet <= quiet + QW'(1);
        if (quiet >= QW'(SETTLE_WINS - 1)) settled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iqb_checks.sv
`timescale 1ns/1ps
module iqb_checks #(
  parameter int CW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ph_valid,
  input logic                 win_end,
  input logic                 any_change,
  input logic                 settled,
  input logic signed [CW-1:0] comp_i,
  input logic signed [CW-1:0] comp_q,
  input logic signed [CW-1:0] comp_g
);
  localparam logic signed [CW-1:0] TOP = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] BOT = {1'b1, {(CW-1){1'b0}}};

  logic signed [CW-1:0] prev_i, prev_q, prev_g;
  logic signed [CW-1:0] d_i, d_q, d_g;

  always_ff @(posedge clk) begin
    prev_i <= comp_i;
    prev_q <= comp_q;
    prev_g <= comp_g;
  end

  assign d_i = comp_i - prev_i;
  assign d_q = comp_q - prev_q;
  assign d_g = comp_g - prev_g;

  p_hold_between_windows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(comp_i) && $stable(comp_q) && $stable(comp_g)));

  p_single_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> ((d_i == '0 || d_i == CW'(1) || d_i == '1) &&
                 (d_q == '0 || d_q == CW'(1) || d_q == '1) &&
                 (d_g == '0 || d_g == CW'(1) || d_g == '1)));

  p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_i == TOP) |=> (comp_i != BOT));

  p_no_wrap_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_i == BOT) |=> (comp_i != TOP));

  p_settled_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_change |=> !settled);

  p_ignore_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_valid |-> !win_end);
endmodule

bind iq_phase_balance_est iqb_checks #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ph_valid   (ph_valid),
  .win_end    (win_end),
  .any_change (any_change),
  .settled    (settled),
  .comp_i     (comp_i),
  .comp_q     (comp_q),
  .comp_g     (comp_g)
);

// File: tb/sim_iq_phase_balance_est.sv
`timescale 1ns/1ps
module sim_iq_phase_balance_est;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ph_valid = 1'b0;
  logic [7:0]        ph_code = '0;
  logic [3:0]        win_log = 4'd2;
  logic [10:0]       dead_band = 11'd1;
  logic signed [7:0] comp_i, comp_q, comp_g;
  logic              settled;

  int n_cmp = 0;
  int n_bad = 0;
  int ei = 0, eq = 0, eg = 0;

  always #2 clk = ~clk;

  iq_phase_balance_est u0 (
    .clk(clk), .rst_n(rst_n), .ph_valid(ph_valid), .ph_code(ph_code),
    .win_log(win_log), .dead_band(dead_band),
    .comp_i(comp_i), .comp_q(comp_q), .comp_g(comp_g), .settled(settled)
  );

  // four codes of a 4-sample window, then expected steps for I, Q, G
  localparam int VEC [6][7] = '{
    '{ 10,  20,  30,  40, -1, -1, -1},
    '{200, 210, 220, 230, -1,  1,  1},
    '{ 70,  80, 100, 120,  1, -1,  0},
    '{  0,  64, 128, 192,  0,  0,  0},
    '{  5, 130, 140, 250,  0,  1, -1},
    '{ 60,  70, 180, 190,  1,  0,  1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int code, input logic v);
    @(negedge clk);
    ph_valid = v;
    ph_code  = 8'(code);
    @(negedge clk);
    ph_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " comp_i"}, int'(comp_i), ei);
    chk({tag, " comp_q"}, int'(comp_q), eq);
    chk({tag, " comp_g"}, int'(comp_g), eg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R5 reset state, R7 settled low
    chk_all("R5 reset");
    chk("R7 reset settled", int'(settled), 0);

    // R1 R2 R3 R4 table walk, R5 mid-window hold
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 3; k++) send(VEC[r][k], 1'b1);
      chk_all("R5 mid-window");
      send(VEC[r][3], 1'b1);
      ei += VEC[r][4];
      eq += VEC[r][5];
      eg += VEC[r][6];
      chk("R1 R4 I step", int'(comp_i), ei);
      chk("R2 R4 Q step", int'(comp_q), eq);
      chk("R3 R4 G step", int'(comp_g), eg);
    end

    // R4 tally equal to dead band holds: I tally=2, Q=4, G=4 with band 2
    dead_band = 11'd2;
    send(10, 1'b1); send(20, 1'b1); send(30, 1'b1); send(100, 1'b1);
    eq -= 1; eg -= 1;
    chk_all("R4 dead band edge");
    dead_band = 11'd1;

    // R8 strobe-less samples ignored
    send(10, 1'b1);
    for (int k = 0; k < 3; k++) send(200, 1'b0);
    chk_all("R8 invalid ignored");
    send(20, 1'b1); send(30, 1'b1); send(40, 1'b1);
    ei -= 1; eq -= 1; eg -= 1;
    chk_all("R8 window after invalid");

    // R7 settled after three quiet windows, clears on change
    for (int w = 0; w < 3; w++) begin
      chk("R7 settled before count", int'(settled), 0);
      for (int k = 0; k < 4; k++) send(VEC[3][k], 1'b1);
    end
    chk("R7 settled after quiet", int'(settled), 1);
    for (int k = 0; k < 4; k++) send(VEC[0][k], 1'b1);
    ei -= 1; eq -= 1; eg -= 1;
    chk("R7 settled drops", int'(settled), 0);
    chk_all("R7 change window");

    // R9 clamp to 1024-sample window, no overflow
    win_log   = 4'd15;
    dead_band = 11'd0;
    for (int k = 0; k < 1023; k++) send(10, 1'b1);
    chk_all("R9 window not yet closed");
    send(10, 1'b1);
    ei -= 1; eq -= 1; eg -= 1;
    chk_all("R9 full window");

    // R6 saturation with one-sample windows
    do_reset();
    win_log = 4'd0;
    ei = 0; eq = 0; eg = 0;
    chk_all("R5 second reset");
    for (int k = 0; k < 140; k++) send(10, 1'b1);
    ei = -128; eq = -128; eg = -128;
    chk_all("R6 low rail");
    for (int k = 0; k < 260; k++) send(100, 1'b1);
    ei = 127;
    chk_all("R6 high rail");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule